// File: doc/BRIEF.md
# FIFO Port Access-Width Controller

This block sits between a CPU data port and a byte-wide packet buffer. Software selects a pipe, an access width of 8, 16 or 32 bits and, for pipe 0 only, a transfer direction, all through one configuration register. Each CPU read or write strobe is then turned into one, two or four consecutive byte operations on the buffer. Read bytes are gathered into a word in little-endian order. Write words are split into bytes, least significant byte first.

The block also enforces the rules for changing the width while a packet is moving. While a packet is being read out, the width is frozen. While a packet is being written, the width may only become narrower. The direction bit is honoured only for pipe 0, and only when it is written together with the pipe selector or after a settling interval of `SETTLE_CYC` clock cycles. Each configuration write carries a field-select mask, which says which of the register's fields the write updates. A byte counter for the selected pipe addresses the buffer. The counter wraps when it reaches the packet length, and that ends the transfer in progress.

Top module: `fifo_port_ctrl`

## Requirements
- R1: After reset the register reads back 0: width code 00 (8-bit), direction 0 (read), pipe 0, error flag 0, no transfer in progress, and no buffer or acknowledge activity.
- R2: The width field sits at register bits [11:10] (00 = 8-bit, 01 = 16-bit, 10 = 32-bit). A write of code 11 leaves the width unchanged and sets the sticky error flag at bit 15. A write whose select bit 3 is set clears the flag, unless the same write raises a new error.
- R3: Register bits [14:12], [9:6] and [4:3] always read 0, whatever value is written to them.
- R4: While a read transfer is in progress, a width write that does not also write the pipe selector (select bit 0) is ignored.
- R5: While a write transfer is in progress, a width write without the pipe selector is accepted only if it does not widen the access. 8 to 16 or 32, and 16 to 32, are ignored.
- R6: When the resulting direction is read, a width write is accepted only if the same write also carries the pipe selector, or carries the direction bit (select bit 1) with pipe 0.
- R7: The effective direction is the register direction bit (bit 5, 1 = write) when the pipe field (bits [2:0]) is 0, and the pipe's entry of `pipeIsWrite` otherwise. A direction write that targets a non-zero pipe is ignored without error.
- R8: For pipe 0, a direction write is accepted if it comes with the pipe selector. A direction write alone is accepted only if at least `SETTLE_CYC` clock edges have passed since the last pipe-selector write. An earlier one is ignored and sets the error flag.
- R9: A CPU read of width N bytes reads N consecutive buffer bytes, one per cycle, starting the cycle after the strobe edge. `cpuAck` pulses N cycles after the strobe edge, with the bytes packed little-endian and the upper bytes zero.
- R10: A CPU write of width N bytes produces N consecutive buffer byte writes, least significant byte first, one per cycle, starting the cycle after the strobe edge. `cpuAck` pulses N cycles after the strobe edge.
- R11: The buffer address is the byte counter. Each byte operation advances it. When the incremented value equals `pktLen`, the counter returns to 0 and that direction's transfer ends. A pipe-selector write clears the counter and both transfer states.
- R12: A CPU strobe that does not match the effective direction, or that arrives while an access is in flight, causes no buffer operation and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrSel | input | 4 | Field select: bit0 pipe, bit1 direction, bit2 width, bit3 clear error |
| cfgWrData | input | 16 | Configuration write data |
| cfgRdData | output | 16 | Configuration readback |
| pipeIsWrite | input | NUM_PIPES | Direction of each non-zero pipe (1 = write) |
| pktLen | input | LEN_W | Packet length in bytes of the selected pipe (0 means 2^LEN_W) |
| cpuRdStb | input | 1 | CPU read request |
| cpuWrStb | input | 1 | CPU write request |
| cpuWrData | input | 32 | CPU write data |
| cpuRdData | output | 32 | CPU read data, valid with cpuAck |
| cpuAck | output | 1 | Access complete pulse |
| bufAddr | output | LEN_W | Buffer byte address |
| bufRdEn | output | 1 | Buffer byte read |
| bufWrEn | output | 1 | Buffer byte write |
| bufWrData | output | 8 | Buffer write byte |
| bufRdData | input | 8 | Buffer read byte (same-cycle) |

## Verification
A configuration write takes effect at the clock edge that samples it, and its result can be read back combinationally in the next half cycle. The bench therefore drives on falling edges and compares the readback at the following falling edge. Byte operations occupy the N cycles that follow the strobe edge, and the acknowledge and packed read data fall in cycle N. The bench checks the address, enables and write byte at each of those falling edges, then the acknowledge, then its removal one cycle later. The settling window is counted in edges by the bench itself, so directed writes land exactly one edge short of the limit and exactly on it.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    W8   = 2'b00,
    W16  = 2'b01,
    W32  = 2'b10,
    WBAD = 2'b11
  } width_e;

  localparam int CPU_BYTES = 4;
  localparam int LANE_W    = $clog2(CPU_BYTES);
  localparam int REG_W     = 16;
  localparam int ERR_BIT   = 15;
  localparam int WID_LO    = 10;
  localparam int WID_HI    = 11;
  localparam int DIR_BIT   = 5;
  localparam int SEL_PIPE  = 0;
  localparam int SEL_DIR   = 1;
  localparam int SEL_WID   = 2;
  localparam int SEL_CLR   = 3;

  typedef struct packed {
    logic   start;
    logic   wr;
    width_e width;
  } dpCmd_t;

  function automatic logic [LANE_W-1:0] lastLane(input width_e w);
    case (w)
      W16:     return LANE_W'(1);
      W32:     return LANE_W'(3);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/fpc_control.sv
module fpc_control
  import fpc_pkg::*;
#(
  parameter int NUM_PIPES  = 8,
  parameter int LEN_W      = 6,
  parameter int SETTLE_CYC = 25
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [3:0]           cfgWrSel,
  input  logic [REG_W-1:0]     cfgWrData,
  input  logic [NUM_PIPES-1:0] pipeIsWrite,
  input  logic [LEN_W-1:0]     pktLen,
  input  logic                 cpuRdStb,
  input  logic                 cpuWrStb,
  input  logic                 dpBusy,
  input  logic                 rdStb,
  input  logic                 wrStb,
  output dpCmd_t               cmd,
  output width_e               widthQ,
  output logic                 dirQ,
  output logic [((NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1)-1:0] pipeQ,
  output logic                 errQ,
  output logic                 readActive,
  output logic                 writeActive,
  output logic [LEN_W-1:0]     bufAddr
);
  localparam int PIPE_W = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1;
  localparam int SET_W  = $clog2(SETTLE_CYC + 1);

  logic [SET_W-1:0] settleCnt;
  logic [LEN_W-1:0] byteCnt, cntInc;
  logic selPipe, selDir, selWid, selClr;
  logic [PIPE_W-1:0] newPipe;
  logic dirAllowed, dirTake, dirErr, newDir, newDirEff, dirEff;
  width_e reqW;
  logic widthErr, lockRd, lockWr, readRule, widthTake, pktEnd;

  always_comb begin
    selPipe    = cfgWrEn & cfgWrSel[SEL_PIPE];
    selDir     = cfgWrEn & cfgWrSel[SEL_DIR];
    selWid     = cfgWrEn & cfgWrSel[SEL_WID];
    selClr     = cfgWrEn & cfgWrSel[SEL_CLR];
    newPipe    = selPipe ? cfgWrData[PIPE_W-1:0] : pipeQ;
    dirAllowed = (newPipe == '0) & (selPipe | (settleCnt == '0));
    dirTake    = selDir & dirAllowed;
    dirErr     = selDir & (newPipe == '0) & ~dirAllowed;
    newDir     = dirTake ? cfgWrData[DIR_BIT] : dirQ;
    newDirEff  = (newPipe == '0) ? newDir : pipeIsWrite[newPipe];
    reqW       = width_e'(cfgWrData[WID_HI:WID_LO]);
    widthErr   = selWid & (reqW == WBAD);
    lockRd     = ~selPipe & readActive;
    lockWr     = ~selPipe & writeActive & (reqW > widthQ);
    readRule   = ~newDirEff & ~(selPipe | ((newPipe == '0) & selDir));
    widthTake  = selWid & ~widthErr & ~lockRd & ~lockWr & ~readRule;
    dirEff     = (pipeQ == '0) ? dirQ : pipeIsWrite[pipeQ];
    cmd.start  = ~dpBusy & ((cpuRdStb & ~dirEff) | (cpuWrStb & dirEff));
    cmd.wr     = dirEff;
    cmd.width  = widthQ;
    cntInc     = byteCnt + 1'b1;
    pktEnd     = (cntInc == pktLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeQ       <= '0;
      dirQ        <= 1'b0;
      widthQ      <= W8;
      errQ        <= 1'b0;
      settleCnt   <= '0;
      byteCnt     <= '0;
      readActive  <= 1'b0;
      writeActive <= 1'b0;
    end else begin
      pipeQ <= newPipe;
      dirQ  <= newDir;
      if (widthTake) widthQ <= reqW;
      if (widthErr | dirErr) errQ <= 1'b1;
      else if (selClr)       errQ <= 1'b0;
      if (selPipe)                settleCnt <= SET_W'(SETTLE_CYC - 1);
      else if (settleCnt != '0)   settleCnt <= settleCnt - 1'b1;
      if (selPipe) begin
        byteCnt     <= '0;
        readActive  <= 1'b0;
        writeActive <= 1'b0;
      end else if (rdStb | wrStb) begin
        if (pktEnd) begin
          byteCnt <= '0;
          if (rdStb) readActive  <= 1'b0;
          if (wrStb) writeActive <= 1'b0;
        end else begin
          byteCnt <= cntInc;
          if (rdStb) readActive  <= 1'b1;
          if (wrStb) writeActive <= 1'b1;
        end
      end
    end
  end

  assign bufAddr = byteCnt;
endmodule

// File: rtl/fpc_datapath.sv
module fpc_datapath
  import fpc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCmd_t                 cmd,
  input  logic [8*CPU_BYTES-1:0] cpuWrData,
  input  logic [7:0]             bufRdData,
  output logic                   busy,
  output logic                   bufRdEn,
  output logic                   bufWrEn,
  output logic [7:0]             bufWrData,
  output logic [8*CPU_BYTES-1:0] cpuRdData,
  output logic                   cpuAck
);
  logic                   wrQ;
  logic [LANE_W-1:0]      lane, lastQ;
  logic [8*CPU_BYTES-1:0] shiftQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      wrQ    <= 1'b0;
      lane   <= '0;
      lastQ  <= '0;
      shiftQ <= '0;
      cpuAck <= 1'b0;
    end else if (cmd.start) begin
      busy   <= 1'b1;
      wrQ    <= cmd.wr;
      lane   <= '0;
      lastQ  <= lastLane(cmd.width);
      shiftQ <= cpuWrData;
      cpuAck <= 1'b0;
    end else begin
      cpuAck <= 1'b0;
      if (busy) begin
        shiftQ <= shiftQ >> 8;
        lane   <= lane + 1'b1;
        if (lane == lastQ) begin
          busy   <= 1'b0;
          cpuAck <= 1'b1;
        end
      end
    end
  end

  for (genvar b = 0; b < CPU_BYTES; b++) begin : g_lane
    logic [7:0] laneQ;
    always_ff @(posedge clk) begin
      if (!rstN)                                    laneQ <= '0;
      else if (cmd.start)                           laneQ <= '0;
      else if (busy && !wrQ && lane == LANE_W'(b))  laneQ <= bufRdData;
    end
    assign cpuRdData[8*b +: 8] = laneQ;
  end

  assign bufRdEn   = busy & ~wrQ;
  assign bufWrEn   = busy & wrQ;
  assign bufWrData = shiftQ[7:0];
endmodule

// File: rtl/fifo_port_ctrl.sv
module fifo_port_ctrl
  import fpc_pkg::*;
#(
  parameter int NUM_PIPES  = 8,
  parameter int LEN_W      = 6,
  parameter int SETTLE_CYC = 25
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [3:0]           cfgWrSel,
  input  logic [15:0]          cfgWrData,
  output logic [15:0]          cfgRdData,
  input  logic [NUM_PIPES-1:0] pipeIsWrite,
  input  logic [LEN_W-1:0]     pktLen,
  input  logic                 cpuRdStb,
  input  logic                 cpuWrStb,
  input  logic [31:0]          cpuWrData,
  output logic [31:0]          cpuRdData,
  output logic                 cpuAck,
  output logic [LEN_W-1:0]     bufAddr,
  output logic                 bufRdEn,
  output logic                 bufWrEn,
  output logic [7:0]           bufWrData,
  input  logic [7:0]           bufRdData
);
  localparam int PIPE_W = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1;

  dpCmd_t            cmd;
  width_e            widthQ;
  logic              dirQ, errQ, readActive, writeActive, dpBusy;
  logic [PIPE_W-1:0] pipeQ;

  fpc_control #(
    .NUM_PIPES(NUM_PIPES), .LEN_W(LEN_W), .SETTLE_CYC(SETTLE_CYC)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrData(cfgWrData), .pipeIsWrite(pipeIsWrite), .pktLen(pktLen),
    .cpuRdStb(cpuRdStb), .cpuWrStb(cpuWrStb), .dpBusy(dpBusy),
    .rdStb(bufRdEn), .wrStb(bufWrEn), .cmd(cmd), .widthQ(widthQ),
    .dirQ(dirQ), .pipeQ(pipeQ), .errQ(errQ), .readActive(readActive),
    .writeActive(writeActive), .bufAddr(bufAddr)
  );

  fpc_datapath u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cpuWrData(cpuWrData),
    .bufRdData(bufRdData), .busy(dpBusy), .bufRdEn(bufRdEn),
    .bufWrEn(bufWrEn), .bufWrData(bufWrData), .cpuRdData(cpuRdData),
    .cpuAck(cpuAck)
  );

  always_comb begin
    cfgRdData                 = '0;
    cfgRdData[ERR_BIT]        = errQ;
    cfgRdData[WID_HI:WID_LO]  = widthQ;
    cfgRdData[DIR_BIT]        = dirQ;
    cfgRdData[PIPE_W-1:0]     = pipeQ;
  end
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWrEn,
  input logic [3:0]  cfgWrSel,
  input logic [15:0] cfgRdData,
  input logic        bufRdEn,
  input logic        bufWrEn,
  input logic        cpuAck,
  input logic        readActive,
  input logic        writeActive
);
  a_r2_width_never_bad: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[11:10] != 2'b11);

  a_r3_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData & 16'h73D8) == 16'h0000);

  a_r4_read_lock: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgWrSel[0] && readActive) |=> $stable(cfgRdData[11:10]));

  a_r5_no_widen: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgWrSel[0] && writeActive) |=>
      (cfgRdData[11:10] <= $past(cfgRdData[11:10])));

  a_r7_dir_other_pipe: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgWrSel[0] && cfgRdData[2:0] != 3'd0) |=> $stable(cfgRdData[5]));

  a_r9_buf_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(bufRdEn && bufWrEn));

  a_r12_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    cpuAck |=> !cpuAck);
endmodule

bind fifo_port_ctrl fpc_checker u_fpc_checker (.*);

// File: tb/test_fifo_port_ctrl.sv
module test_fifo_port_ctrl;
  localparam int SETTLE = 25;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgWrSel = '0;
  logic [15:0] cfgWrData = '0;
  logic [15:0] cfgRdData;
  logic [7:0]  pipeIsWrite = 8'b1010_1010;
  logic [5:0]  pktLen = 6'd8;
  logic        cpuRdStb = 1'b0, cpuWrStb = 1'b0;
  logic [31:0] cpuWrData = '0, cpuRdData;
  logic        cpuAck, bufRdEn, bufWrEn;
  logic [5:0]  bufAddr;
  logic [7:0]  bufWrData, bufRdData;
  logic [7:0]  mem [64];

  int checks = 0, errors = 0;
  logic [1:0] mWidth = 2'b00;
  logic       mDir = 1'b0, mErr = 1'b0, mRdAct = 1'b0, mWrAct = 1'b0;
  logic [2:0] mPipe = 3'd0;
  logic [5:0] mCnt = 6'd0;
  int         mSince = 1000;

  always #4 clk = ~clk;

  fifo_port_ctrl i_fifo_port_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .pipeIsWrite(pipeIsWrite),
    .pktLen(pktLen), .cpuRdStb(cpuRdStb), .cpuWrStb(cpuWrStb),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .cpuAck(cpuAck),
    .bufAddr(bufAddr), .bufRdEn(bufRdEn), .bufWrEn(bufWrEn),
    .bufWrData(bufWrData), .bufRdData(bufRdData)
  );

  assign bufRdData = mem[bufAddr];
  always @(posedge clk) if (bufWrEn) mem[bufAddr] <= bufWrData;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic tick();
    @(negedge clk);
    if (mSince < 1000) mSince++;
  endtask

  function automatic logic [15:0] expReg();
    logic [15:0] r = '0;
    r[15] = mErr; r[11:10] = mWidth; r[5] = mDir; r[2:0] = mPipe;
    return r;
  endfunction

  function automatic logic effDir();
    return (mPipe == 3'd0) ? mDir : pipeIsWrite[mPipe];
  endfunction

  // Expected register update from R2, R4-R8, R11
  task automatic modelCfg(input logic [3:0] sel, input logic [15:0] d);
    logic [2:0] nPipe = sel[0] ? d[2:0] : mPipe;
    logic nDir = mDir, errEv = 1'b0, nEff;
    logic [1:0] c = d[11:10];
    if (sel[0]) begin mRdAct = 0; mWrAct = 0; mCnt = 0; end
    if (sel[1] && nPipe == 3'd0) begin
      if (sel[0] || mSince + 1 >= SETTLE) nDir = d[5];
      else errEv = 1'b1;
    end
    nEff = (nPipe == 3'd0) ? nDir : pipeIsWrite[nPipe];
    if (sel[2]) begin
      if (c == 2'b11) errEv = 1'b1;
      else if (mRdAct) ;
      else if (mWrAct && c > mWidth) ;
      else if (!nEff && !(sel[0] || (nPipe == 3'd0 && sel[1]))) ;
      else mWidth = c;
    end
    if (errEv) mErr = 1'b1;
    else if (sel[3]) mErr = 1'b0;
    mPipe = nPipe;
    mDir  = nDir;
  endtask

  task automatic modelByte(input logic isWr);
    logic [5:0] nx = mCnt + 6'd1;
    if (nx == pktLen) begin
      mCnt = 0;
      if (isWr) mWrAct = 0; else mRdAct = 0;
    end else begin
      mCnt = nx;
      if (isWr) mWrAct = 1; else mRdAct = 1;
    end
  endtask

  task automatic cfgWrite(input logic [3:0] sel, input logic [15:0] d);
    cfgWrEn = 1'b1; cfgWrSel = sel; cfgWrData = d;
    modelCfg(sel, d);
    tick();
    cfgWrEn = 1'b0;
    if (sel[0]) mSince = 0;
    chk("R2/R3/R4/R5/R6/R7/R8 readback", {16'h0, cfgRdData}, {16'h0, expReg()});
  endtask

  task automatic cpuAccess(input logic isRd, input logic [31:0] d);
    logic dEff = effDir();
    logic bad = 1'b0;
    logic [31:0] expRd = '0;
    int n;
    cpuRdStb = isRd; cpuWrStb = !isRd; cpuWrData = d;
    tick();
    cpuRdStb = 1'b0; cpuWrStb = 1'b0;
    if (isRd == dEff) begin
      for (int k = 0; k < 3; k++) begin
        bad |= bufRdEn | bufWrEn | cpuAck;
        tick();
      end
      chk("R12 mismatched strobe ignored", {31'h0, bad}, 32'h0);
    end else begin
      n = 1 << mWidth;
      for (int i = 0; i < n; i++) begin
        if (bufRdEn !== isRd || bufWrEn !== !isRd || bufAddr !== mCnt) bad = 1'b1;
        if (isRd) expRd[8*i +: 8] = mem[mCnt];
        else if (bufWrData !== d[8*i +: 8]) bad = 1'b1;
        modelByte(!isRd);
        tick();
      end
      chk("R9/R10/R11 byte sequence", {31'h0, bad}, 32'h0);
      chk("R9/R10 ack after N cycles", {31'h0, cpuAck}, 32'h1);
      if (isRd) chk("R9 packed read data", cpuRdData, expRd);
      tick();
      chk("R9/R10 ack single pulse", {31'h0, cpuAck}, 32'h0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h0005EED1));
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1
    chk("R1 reset register", {16'h0, cfgRdData}, 32'h0);
    chk("R1 reset activity", {29'h0, bufRdEn, bufWrEn, cpuAck}, 32'h0);

    // R2
    cfgWrite(4'b0101, 16'h0400);
    chk("R2 width 16 accepted", {30'h0, cfgRdData[11:10]}, 32'h1);
    cfgWrite(4'b0101, 16'h0C00);
    chk("R2 code 11 kept width", {30'h0, cfgRdData[11:10]}, 32'h1);
    chk("R2 error set", {31'h0, cfgRdData[15]}, 32'h1);
    cfgWrite(4'b1000, 16'h0000);
    chk("R2 error cleared", {31'h0, cfgRdData[15]}, 32'h0);
    // R6
    cfgWrite(4'b0100, 16'h0800);
    chk("R6 lone width on read pipe ignored", {30'h0, cfgRdData[11:10]}, 32'h1);
    // R3
    cfgWrite(4'b0111, 16'hFFFF);
    chk("R3 unused bits zero", {16'h0, cfgRdData & 16'h73D8}, 32'h0);
    cfgWrite(4'b1000, 16'h0000);

    // R8
    cfgWrite(4'b0001, 16'h0000);
    cfgWrite(4'b0010, 16'h0020);
    chk("R8 early direction ignored", {31'h0, cfgRdData[5]}, 32'h0);
    chk("R8 early direction error", {31'h0, cfgRdData[15]}, 32'h1);
    while (mSince < SETTLE - 2) tick();
    cfgWrite(4'b0010, 16'h0020);
    chk("R8 one edge short ignored", {31'h0, cfgRdData[5]}, 32'h0);
    cfgWrite(4'b1010, 16'h0020);
    chk("R8 settled direction accepted", {31'h0, cfgRdData[5]}, 32'h1);
    chk("R8 error cleared", {31'h0, cfgRdData[15]}, 32'h0);

    // R7, R12
    cfgWrite(4'b0011, 16'h0001);
    chk("R7 direction on pipe 1 ignored", {31'h0, cfgRdData[5]}, 32'h1);
    cpuAccess(1'b0, 32'h0000_BEEF);
    cpuAccess(1'b1, 32'h0);

    // R9, R4, R11
    cfgWrite(4'b0111, 16'h0800);
    cpuAccess(1'b1, 32'h0);
    repeat (SETTLE) tick();
    cfgWrite(4'b0110, 16'h0000);
    chk("R4 width locked during read", {30'h0, cfgRdData[11:10]}, 32'h2);
    cpuAccess(1'b1, 32'h0);
    cfgWrite(4'b0110, 16'h0000);
    chk("R4/R11 width free after packet end", {30'h0, cfgRdData[11:10]}, 32'h0);

    // R5
    cfgWrite(4'b0111, 16'h0420);
    cpuAccess(1'b0, 32'h0000_A5C3);
    repeat (SETTLE) tick();
    cfgWrite(4'b0110, 16'h0820);
    chk("R5 widen ignored during write", {30'h0, cfgRdData[11:10]}, 32'h1);
    cfgWrite(4'b0110, 16'h0020);
    chk("R5 narrow accepted during write", {30'h0, cfgRdData[11:10]}, 32'h0);
    // R11: pipe write restarts the counter at 0
    cfgWrite(4'b0011, 16'h0020);
    cpuAccess(1'b0, 32'h0000_005A);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int r = $urandom % 10;
      if (r < 3) begin
        logic [15:0] d = 16'($urandom);
        if ($urandom % 2) d[2:0] = 3'd0;
        cfgWrite(4'($urandom), d);
      end else if (r < 4) begin
        repeat ($urandom % 30) tick();
      end else if (r < 5) begin
        pktLen = 6'(1 + $urandom % 20);
      end else begin
        cpuAccess(1'($urandom), $urandom);
      end
    end

    summary();
    $finish;
  end
endmodule